// File: doc/BRIEF.md
# Programmable Interrupt Controller Core

This block arbitrates among eight edge-triggered interrupt lines and hands a processor one vector at a time. Software reaches it through two byte-wide addresses. The command address (`addr` = 0) accepts initialization and operation commands and returns a selectable status register. The data address (`addr` = 1) accepts the remaining initialization words and the mask, and it always reads back the mask.

A rising edge on a request line latches a pending bit. The block compares the pending bits with the mask and raises `irq_out`. It also presents a vector equal to the programmed base plus the index of the winning line. Line 0 has the highest priority. When the processor pulses `ack`, the winning line moves from pending to in-service. Software later retires it with a specific or a non-specific end-of-interrupt command.

Before the block takes operation commands or mask writes, software must run an initialization sequence. The sequence always starts with word 1 on the command address and takes word 2 on the data address. Words 3 and 4 follow on the data address only if word 1 asks for them.

Top module: `irqctl_core`

## Requirements
- R1: After reset the pending, mask and in-service registers are zero, `irq_out` is low, the command-address readback is zero, and the sequencer waits for word 1. A data write made before word 1 leaves the mask at zero.
- R2: A command write with bit 4 set is word 1, in any state. Its bit 1 set means single mode (no word 3), and its bit 0 set means word 4 is expected. The next data write is word 2, which sets the vector base.
- R3: After word 2, one data write is consumed as word 3 when word 1 had bit 1 clear. Then one more data write is consumed as word 4 when word 1 had bit 0 set. After that the block is ready. Data writes consumed as words 2 to 4 do not change the mask.
- R4: A data read returns the mask. A data write in the ready state loads the mask.
- R5: A rising edge on `req_in[i]` sets pending bit i. The bit stays set until it is acknowledged, and a line that stays high does not set it again.
- R6: `irq_out` is high exactly when some pending bit has its mask bit clear.
- R7: The winner is the lowest-indexed line that is pending and unmasked. `vector` equals the base plus the winner's index, modulo 256.
- R8: An `ack` pulse while `irq_out` is high sets the winner's in-service bit and clears its pending bit. An `ack` pulse while `irq_out` is low changes nothing.
- R9: A command write in the ready state with bits 4:3 = 01 selects the command-address readback from its bits 1:0: 10 returns the pending register, 11 returns the in-service register, and any other value returns zero.
- R10: A command write in the ready state with bits 4:3 = 00, bit 7 = 0, bit 6 = 1 and bit 5 = 1 is a specific end-of-interrupt. It clears the in-service bit whose index is in bits 2:0.
- R11: The same command with bit 6 = 0 is a non-specific end-of-interrupt. It clears only the lowest-numbered set in-service bit.
- R12: Any other command with bits 4:3 = 00 changes nothing. A command write outside the ready state that is not word 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| addr | input | 1 | 0 selects the command address, 1 selects the data address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| req_in | input | 8 | Interrupt request lines |
| ack | input | 1 | Acknowledge pulse from the processor |
| irq_out | output | 1 | Interrupt pending toward the processor |
| vector | output | 8 | Vector of the current winner |

## Verification
A corrupted pending, mask or in-service bit shows up one clock after the write, edge or acknowledge that caused it. It appears on `irq_out` and `vector` at once, and on `rdata` as soon as the matching readback is selected. A sequencer stuck in the wrong initialization step shows up as a mask write that has no effect, or as a vector built on the wrong base. The bench therefore reads back every register after each command that should change it. It also keeps `vector` under watch while the winner changes.

// File: rtl/irqctl_pkg.sv
package irqctl_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_W1 = 3'd0,
    ST_WAIT_W2 = 3'd1,
    ST_WAIT_W3 = 3'd2,
    ST_WAIT_W4 = 3'd3,
    ST_READY   = 3'd4
  } seq_state_e;

  // command-byte field positions the decoder depends on
  localparam int unsigned B_INIT  = 4;
  localparam int unsigned B_OCSEL = 3;
  localparam int unsigned B_ROT   = 7;
  localparam int unsigned B_SPEC  = 6;
  localparam int unsigned B_EOI   = 5;
  localparam int unsigned B_SNGL  = 1;
  localparam int unsigned B_NEED4 = 0;

  localparam logic [1:0] RSEL_PEND = 2'b10;
  localparam logic [1:0] RSEL_INSV = 2'b11;

endpackage

// File: rtl/irqctl_edge.sv
module irqctl_edge #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] req_in,
  input  logic [N_LINES-1:0] clr,
  output logic [N_LINES-1:0] rise,
  output logic [N_LINES-1:0] pend
);

  logic [N_LINES-1:0] req_q;

  assign rise = req_in & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
      pend  <= '0;
    end else begin
      req_q <= req_in;
      pend  <= (pend & ~clr) | rise;
    end
  end

endmodule

// File: rtl/irqctl_prio.sv
module irqctl_prio #(
  parameter int unsigned N_LINES = 8,
  localparam int unsigned IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic [N_LINES-1:0] vec,
  output logic               any,
  output logic [N_LINES-1:0] onehot,
  output logic [IW-1:0]      idx
);

  logic [N_LINES:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N_LINES; i++) begin : g_chain
    assign onehot[i]  = vec[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | vec[i];
  end

  assign any = seen[N_LINES];

  function automatic logic [IW-1:0] f_encode(input logic [N_LINES-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int k = 0; k < N_LINES; k++) begin
      if (oh[k]) r = r | IW'(k);
    end
    return r;
  endfunction

  assign idx = f_encode(onehot);

endmodule

// File: rtl/irqctl_seq.sv
module irqctl_seq
  import irqctl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_wr,
  input  logic data_wr,
  input  logic is_init,
  input  logic sngl_bit,
  input  logic need4_bit,
  output logic ready,
  output logic base_load
);

  seq_state_e st;
  logic       single_q;
  logic       need4_q;

  assign ready     = (st == ST_READY);
  assign base_load = data_wr && (st == ST_WAIT_W2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_WAIT_W1;
      single_q <= 1'b0;
      need4_q  <= 1'b0;
    end else if (cmd_wr && is_init) begin
      st       <= ST_WAIT_W2;
      single_q <= sngl_bit;
      need4_q  <= need4_bit;
    end else if (data_wr) begin
      case (st)
        ST_WAIT_W2: st <= !single_q ? ST_WAIT_W3 : (need4_q ? ST_WAIT_W4 : ST_READY);
        ST_WAIT_W3: st <= need4_q ? ST_WAIT_W4 : ST_READY;
        ST_WAIT_W4: st <= ST_READY;
        default:    st <= st;
      endcase
    end
  end

endmodule

// File: rtl/irqctl_core.sv
module irqctl_core
  import irqctl_pkg::*;
#(
  parameter int unsigned N_LINES = 8,
  parameter int unsigned DW      = 8,
  localparam int unsigned IW = (N_LINES > 1) ? $clog2(N_LINES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               addr,
  input  logic [DW-1:0]      wdata,
  output logic [DW-1:0]      rdata,
  input  logic [N_LINES-1:0] req_in,
  input  logic               ack,
  output logic               irq_out,
  output logic [DW-1:0]      vector
);

  // named internal events
  logic               cmd_wr, data_wr, ready, base_load;
  logic               op2_wr, op3_wr, eoi_sp, eoi_ns, ack_take;
  logic [N_LINES-1:0] rise, irr, imr, isr, pend_open;
  logic [N_LINES-1:0] win_oh, isr_low_oh, eoi_clr, ack_set, sp_oh;
  logic [IW-1:0]      win_idx, isr_low_idx;
  logic               isr_any;
  logic [DW-1:0]      base;
  logic [1:0]         rsel;

  assign cmd_wr  = wr_en & ~addr;
  assign data_wr = wr_en & addr;

  irqctl_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_wr    (cmd_wr),
    .data_wr   (data_wr),
    .is_init   (wdata[B_INIT]),
    .sngl_bit  (wdata[B_SNGL]),
    .need4_bit (wdata[B_NEED4]),
    .ready     (ready),
    .base_load (base_load)
  );

  irqctl_edge #(.N_LINES(N_LINES)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_in (req_in),
    .clr    (ack_set),
    .rise   (rise),
    .pend   (irr)
  );

  assign pend_open = irr & ~imr;

  irqctl_prio #(.N_LINES(N_LINES)) u_win (
    .vec    (pend_open),
    .any    (irq_out),
    .onehot (win_oh),
    .idx    (win_idx)
  );

  irqctl_prio #(.N_LINES(N_LINES)) u_isr_low (
    .vec    (isr),
    .any    (isr_any),
    .onehot (isr_low_oh),
    .idx    (isr_low_idx)
  );

  // command decode
  assign op2_wr = cmd_wr & ready & ~wdata[B_INIT] & ~wdata[B_OCSEL];
  assign op3_wr = cmd_wr & ready & ~wdata[B_INIT] &  wdata[B_OCSEL];
  assign eoi_sp = op2_wr & wdata[B_EOI] & ~wdata[B_ROT] &  wdata[B_SPEC];
  assign eoi_ns = op2_wr & wdata[B_EOI] & ~wdata[B_ROT] & ~wdata[B_SPEC];

  function automatic logic [N_LINES-1:0] f_level_oh(input logic [2:0] lvl);
    logic [N_LINES-1:0] r;
    r = '0;
    for (int k = 0; k < N_LINES; k++) begin
      if (lvl == 3'(k)) r[k] = 1'b1;
    end
    return r;
  endfunction

  function automatic logic [DW-1:0] f_vector(input logic [DW-1:0] b, input logic [IW-1:0] i);
    return b + DW'(i);
  endfunction

  assign sp_oh    = f_level_oh(wdata[2:0]);
  assign eoi_clr  = eoi_sp ? sp_oh : (eoi_ns && isr_any) ? isr_low_oh : '0;
  assign ack_take = ack & irq_out;
  assign ack_set  = ack_take ? win_oh : '0;
  assign vector   = f_vector(base, win_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr  <= '0;
      imr  <= '0;
      base <= '0;
      rsel <= 2'b00;
    end else begin
      isr <= (isr & ~eoi_clr) | ack_set;
      if (data_wr && ready) imr  <= wdata[N_LINES-1:0];
      if (base_load)        base <= wdata;
      if (op3_wr)           rsel <= wdata[1:0];
    end
  end

  always_comb begin
    if (addr) begin
      rdata = DW'(imr);
    end else begin
      case (rsel)
        RSEL_PEND: rdata = DW'(irr);
        RSEL_INSV: rdata = DW'(isr);
        default:   rdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/irqctl_core_chk.sv
module irqctl_core_chk #(
  parameter int unsigned N_LINES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ack_take,
  input logic               eoi_ns,
  input logic               ready,
  input logic               irq_out,
  input logic [N_LINES-1:0] win_oh,
  input logic [N_LINES-1:0] rise,
  input logic [N_LINES-1:0] irr,
  input logic [N_LINES-1:0] imr,
  input logic [N_LINES-1:0] isr
);

  a_r8_ack_sets_insv: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> ((isr & $past(win_oh)) == $past(win_oh)));

  a_r8_ack_clears_pend: assert property (@(posedge clk) disable iff (!rst_n)
    ack_take |=> ((irr & $past(win_oh & ~rise)) == '0));

  a_r7_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh));

  a_r7_winner_open: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_oh & imr) == '0) && ((win_oh & ~irr) == '0));

  a_r6_irq_has_winner: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (win_oh != '0));

  a_r11_ns_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_ns && !ack_take && (isr != '0)) |=> ($countones(isr) + 1 == $countones($past(isr))));

  a_r3_mask_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> $stable(imr));

  a_r5_edge_latches: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != '0) |=> ((irr & $past(rise)) == $past(rise)));

endmodule

bind irqctl_core irqctl_core_chk #(.N_LINES(N_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ack_take (ack_take),
  .eoi_ns   (eoi_ns),
  .ready    (ready),
  .irq_out  (irq_out),
  .win_oh   (win_oh),
  .rise     (rise),
  .irr      (irr),
  .imr      (imr),
  .isr      (isr)
);

// File: tb/irqctl_core_test.sv
module irqctl_core_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       addr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [7:0] req_in = 8'h00;
  logic       ack = 1'b0;
  logic       irq_out;
  logic [7:0] vector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irqctl_core uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .req_in(req_in), .ack(ack), .irq_out(irq_out), .vector(vector)
  );

  // {request pulse, mask, expected irq, expected vector} with base 0x20
  localparam logic [31:0] TBL [0:6] = '{
    {8'h01, 8'h00, 8'h01, 8'h20},
    {8'h80, 8'h00, 8'h01, 8'h27},
    {8'h0C, 8'h04, 8'h01, 8'h23},
    {8'hF0, 8'h00, 8'h01, 8'h24},
    {8'hFF, 8'hFF, 8'h00, 8'h00},
    {8'h50, 8'h10, 8'h01, 8'h26},
    {8'hA2, 8'h02, 8'h01, 8'h25}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; addr = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    addr = a; #1; d = rdata; addr = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] p);
    @(negedge clk); req_in = p;
    @(negedge clk); req_in = 8'h00;
  endtask

  task automatic do_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {7'd0, irq_out}, 8'h00);
    rd(1'b1, v); chk("R1 mask after reset", v, 8'h00);
    rd(1'b0, v); chk("R1 cmd readback after reset", v, 8'h00);
    wr(1'b1, 8'h55);
    rd(1'b1, v); chk("R1 data write before init", v, 8'h00);

    // R2: single mode with word 4
    wr(1'b0, 8'h13);
    wr(1'b1, 8'h20);
    wr(1'b1, 8'h5A);
    rd(1'b1, v); chk("R3 word4 not loaded to mask", v, 8'h00);
    wr(1'b1, 8'h3C);
    rd(1'b1, v); chk("R4 mask load", v, 8'h3C);
    wr(1'b1, 8'h00);
    wr(1'b0, 8'h0A);

    for (int i = 0; i < 7; i++) begin
      wr(1'b1, TBL[i][23:16]);
      pulse(TBL[i][31:24]);
      chk($sformatf("R6 irq entry %0d", i), {7'd0, irq_out}, TBL[i][15:8]);
      if (TBL[i][8]) chk($sformatf("R7 vector entry %0d", i), vector, TBL[i][7:0]);
      rd(1'b0, v); chk($sformatf("R5 pending entry %0d", i), v, TBL[i][31:24]);
      wr(1'b1, 8'h00);
      for (int k = 0; k < 8; k++) if (irq_out) do_ack();
      for (int k = 0; k < 8; k++) wr(1'b0, 8'h20);
    end

    // acknowledge and end-of-interrupt
    pulse(8'h28);
    chk("R7 vector line 3", vector, 8'h23);
    do_ack();
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R8 insv after ack", v, 8'h08);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R8 pending after ack", v, 8'h20);
    chk("R7 vector line 5", vector, 8'h25);
    do_ack();
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R8 insv two lines", v, 8'h28);
    chk("R8 irq idle", {7'd0, irq_out}, 8'h00);
    do_ack();
    rd(1'b0, v); chk("R8 idle ack no effect", v, 8'h28);
    wr(1'b0, 8'hA0);
    rd(1'b0, v); chk("R12 rotate cmd rejected", v, 8'h28);
    wr(1'b0, 8'h40);
    rd(1'b0, v); chk("R12 no-eoi cmd rejected", v, 8'h28);
    wr(1'b0, 8'h20);
    rd(1'b0, v); chk("R11 non-specific eoi", v, 8'h20);
    wr(1'b0, 8'h65);
    rd(1'b0, v); chk("R10 specific eoi", v, 8'h00);
    wr(1'b0, 8'h08);
    rd(1'b0, v); chk("R9 select zero", v, 8'h00);

    // held level does not re-latch
    @(negedge clk); req_in = 8'h02;
    @(negedge clk);
    do_ack();
    repeat (3) @(negedge clk);
    chk("R5 held line no relatch irq", {7'd0, irq_out}, 8'h00);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); chk("R5 held line pending", v, 8'h00);
    req_in = 8'h00;
    wr(1'b0, 8'h61);

    // cascade re-init, wrap of vector
    pulse(8'h40);
    wr(1'b0, 8'h10);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); chk("R12 cmd outside ready ignored", v, 8'h40);
    wr(1'b1, 8'hFC);
    wr(1'b1, 8'h99);
    rd(1'b1, v); chk("R3 word3 not loaded to mask", v, 8'h00);
    chk("R2 R7 vector wraps", vector, 8'h02);
    wr(1'b1, 8'h40);
    chk("R6 masked line drops irq", {7'd0, irq_out}, 8'h00);
    rd(1'b1, v); chk("R4 mask after cascade init", v, 8'h40);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual %h expected %h", 8'h01, 8'h00);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule